// File: doc/BRIEF.md
# Maskable Interrupt Source Register

This block records the events reported by a network MAC and turns them into one level-sensitive interrupt line. The transmit, receive and control-frame logic each raise single-cycle event pulses. Every pulse sets a sticky flag in a seven-bit source register. A seven-bit enable register decides which of those flags may drive the interrupt line. Both registers are reached over a simple 32-bit register bus.

A flag records its event even while its enable bit is off. The enable register therefore gates only the line, never the recorded status. Software reads the source register to find pending events. It acknowledges them by writing ones to the bits it has handled; zero bits in that write leave their flags alone. The interrupt line is registered. It is high whenever at least one flag is both set and enabled.

Flag positions, shared by both registers:
- bit 0: transmit frame completed
- bit 1: transmit error
- bit 2: receive frame
- bit 3: receive error
- bit 4: received frame dropped because no receive buffer was free
- bit 5: transmit control frame
- bit 6: receive control frame

Top module: `irq_status_unit`

## Requirements
- R1: After reset the source flags, the enable bits, the interrupt line and the read data are all zero.
- R2: An event pulse on `evt_i[k]` sets source flag k at the next clock edge, whatever enable bit k holds. The flag then stays set until it is cleared. Event bit k maps to flag bit k, using the positions listed above.
- R3: A bus write to byte offset 0x04 clears every source flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: When an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: A bus write to byte offset 0x08 loads data bits 6:0 into the enable register. A read of offset 0x08 returns that value.
- R6: `irq_o` is high one cycle after (source AND enable) is non-zero, and low one cycle after it is zero.
- R7: Data bits 31:7 always read as zero. Writing ones to those bits has no effect.
- R8: Writes to any offset other than 0x04 or 0x08 change nothing. Reads of such an offset return zero.
- R9: A read (`bus_en`=1, `bus_we`=0) returns, on `bus_rdata` after that clock edge, the register value held before the edge. `bus_rdata` holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_i | input | 7 | Event pulses, one per source flag |
| irq_o | output | 1 | Level interrupt: any enabled flag set |

## Verification
A wrong source flag shows up on the next source read. If that flag is enabled, it also shows up on `irq_o` one cycle after the bad edge. A lost event, a clear applied to the wrong bit, or a clear that beats a simultaneous event all appear that way. A corrupted enable bit is visible only on an enable read, or through the line once a matching flag is pending. That is why the bench sets flags under several enable patterns and reads back both registers after every step.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Event positions shared by the source and enable registers
    typedef enum int {
        EVB_TX_DONE  = 0,
        EVB_TX_ERR   = 1,
        EVB_RX_FRAME = 2,
        EVB_RX_ERR   = 3,
        EVB_RX_DROP  = 4,
        EVB_TX_CTRL  = 5,
        EVB_RX_CTRL  = 6
    } evt_bit_e;

    localparam int unsigned EVT_COUNT = 7;

    // Decoded bus access for one cycle
    typedef struct packed {
        logic wr_src;
        logic wr_mask;
        logic rd;
        logic sel_src;
        logic sel_mask;
    } bus_dec_t;

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
    parameter int unsigned NUM_EVT = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               clr_en_i,
    input  logic [NUM_EVT-1:0] clr_bits_i,
    output logic [NUM_EVT-1:0] src_o
);

    typedef struct packed {
        logic [NUM_EVT-1:0] src;
    } src_state_t;

    src_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (clr_en_i && clr_bits_i[i]) st_d.src[i] = 1'b0;
            if (evt_i[i])                  st_d.src[i] = 1'b1;  // set wins
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src_o = st_q.src;

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_chk
        // R2, R4: an event always leaves its flag set
        p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[g] |=> src_o[g]);
        // R3: a clear without a competing event empties the flag
        p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en_i && clr_bits_i[g] && !evt_i[g]) |=> !src_o[g]);
        // R3: no event and no clear leaves the flag alone
        p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt_i[g] && !(clr_en_i && clr_bits_i[g])) |=> $stable(src_o[g]));
    end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int unsigned NUM_EVT = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [NUM_EVT-1:0] wdata_i,
    output logic [NUM_EVT-1:0] mask_o
);

    typedef struct packed {
        logic [NUM_EVT-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) st_d.mask = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;

    // R5: load on write, hold otherwise
    p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (mask_o == $past(wdata_i)));
    p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(mask_o));

endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
    parameter int unsigned NUM_EVT = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] src_i,
    input  logic [NUM_EVT-1:0] mask_i,
    output logic               irq_o
);

    typedef struct packed {
        logic irq;
    } line_state_t;

    line_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(src_i & mask_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    // R6: line follows enabled pending flags one cycle later
    p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_i & mask_i)) |=> irq_o);
    p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(src_i & mask_i)) |=> !irq_o);

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port #(
    parameter int unsigned NUM_EVT = 7,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en_i,
    input  logic               sel_src_i,
    input  logic               sel_mask_i,
    input  logic [NUM_EVT-1:0] src_i,
    input  logic [NUM_EVT-1:0] mask_i,
    output logic [DATA_W-1:0]  rdata_o
);

    localparam int unsigned PAD_W = DATA_W - NUM_EVT;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t          st_d, st_q;
    logic [NUM_EVT-1:0] pick;

    always_comb begin
        st_d = st_q;
        pick = '0;
        if (sel_src_i)       pick = src_i;
        else if (sel_mask_i) pick = mask_i;
        if (rd_en_i) st_d.rdata = {{PAD_W{1'b0}}, pick};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;

    // R7: padding bits never reach the bus
    p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[DATA_W-1:NUM_EVT] == '0);
    // R9: read data holds between reads
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o));

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_pkg::*;
#(
    parameter int unsigned       NUM_EVT   = EVT_COUNT,
    parameter int unsigned       DATA_W    = 32,
    parameter int unsigned       ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] SRC_ADDR  = 8'h04,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h08
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               irq_o
);

    bus_dec_t           dec;
    logic [NUM_EVT-1:0] src;
    logic [NUM_EVT-1:0] mask;

    always_comb begin
        dec          = '0;
        dec.sel_src  = (bus_addr == SRC_ADDR);
        dec.sel_mask = (bus_addr == MASK_ADDR);
        dec.wr_src   = bus_en && bus_we && dec.sel_src;
        dec.wr_mask  = bus_en && bus_we && dec.sel_mask;
        dec.rd       = bus_en && !bus_we;
    end

    irq_src_bank #(.NUM_EVT(NUM_EVT)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .clr_en_i   (dec.wr_src),
        .clr_bits_i (bus_wdata[NUM_EVT-1:0]),
        .src_o      (src)
    );

    irq_mask_reg #(.NUM_EVT(NUM_EVT)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (dec.wr_mask),
        .wdata_i (bus_wdata[NUM_EVT-1:0]),
        .mask_o  (mask)
    );

    irq_line_gen #(.NUM_EVT(NUM_EVT)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src),
        .mask_i (mask),
        .irq_o  (irq_o)
    );

    irq_read_port #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (dec.rd),
        .sel_src_i  (dec.sel_src),
        .sel_mask_i (dec.sel_mask),
        .src_i      (src),
        .mask_i     (mask),
        .rdata_o    (bus_rdata)
    );

    // R8: unmapped writes leave both registers untouched
    p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && !dec.sel_src && !dec.sel_mask && evt_i == '0)
        |=> ($stable(mask) && $stable(src)));

endmodule

// File: tb/irq_status_unit_tb.sv
`timescale 1ns/100ps
module irq_status_unit_tb_top;

    localparam logic [7:0] A_SRC  = 8'h04;
    localparam logic [7:0] A_MASK = 8'h08;
    localparam logic [7:0] A_OTH  = 8'h0C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  evt = '0;
    logic        irq;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_i(evt), .irq_o(irq)
    );

    // {enable[6:0], events[6:0], clear[6:0], exp_src[6:0], exp_irq}
    localparam int NV = 8;
    localparam logic [28:0] VEC [NV] = '{
        {7'h00, 7'h05, 7'h00, 7'h05, 1'b0},  // R2 set while disabled
        {7'h04, 7'h00, 7'h00, 7'h05, 1'b1},  // R6 enable a pending flag
        {7'h04, 7'h10, 7'h04, 7'h11, 1'b0},  // R3 clear enabled flag
        {7'h7F, 7'h40, 7'h01, 7'h50, 1'b1},  // R2 R3 mixed
        {7'h7F, 7'h08, 7'h08, 7'h58, 1'b1},  // R4 set beats clear
        {7'h20, 7'h20, 7'h58, 7'h20, 1'b1},  // R4 R3 multi-bit clear
        {7'h00, 7'h00, 7'h00, 7'h20, 1'b0},  // R6 enable off drops line
        {7'h7F, 7'h00, 7'h7F, 7'h00, 1'b0}   // R3 clear all
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic step(input logic en, input logic we, input logic [7:0] a,
                        input logic [31:0] d, input logic [6:0] e);
        bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d; evt = e;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; evt = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        step(1'b1, 1'b0, a, 32'h0, 7'h0);
        v = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog all-reqs actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 irq after reset", {31'h0, irq}, 32'h0);
        chk("R1 rdata after reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_SRC, v);  chk("R1 source after reset", v, 32'h0);
        rd(A_MASK, v); chk("R1 enable after reset", v, 32'h0);

        // Table walk: R2 R3 R4 R6
        for (int i = 0; i < NV; i++) begin
            step(1'b1, 1'b1, A_MASK, {25'h0, VEC[i][28:22]}, 7'h0);
            step(1'b1, 1'b1, A_SRC,  {25'h0, VEC[i][14:8]}, VEC[i][21:15]);
            rd(A_SRC, v);
            chk($sformatf("R2/R3/R4 source vec %0d", i), v, {25'h0, VEC[i][7:1]});
            chk($sformatf("R6 irq vec %0d", i), {31'h0, irq}, {31'h0, VEC[i][0]});
        end

        // R6 exact latency: event with its enable bit set
        step(1'b1, 1'b1, A_MASK, 32'h2, 7'h0);
        step(1'b0, 1'b0, 8'h0, 32'h0, 7'h02);
        chk("R6 irq low same edge as set", {31'h0, irq}, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R6 irq high one cycle later", {31'h0, irq}, 32'h1);

        // R5 R7 enable write with upper ones
        step(1'b1, 1'b1, A_MASK, 32'hFFFF_FF2A, 7'h0);
        rd(A_MASK, v); chk("R5/R7 enable readback", v, 32'h0000_002A);

        // R8 unmapped write and read
        step(1'b1, 1'b1, A_OTH, 32'hFFFF_FFFF, 7'h0);
        rd(A_MASK, v); chk("R8 enable untouched", v, 32'h0000_002A);
        rd(A_SRC, v);  chk("R8 source untouched", v, 32'h0000_0002);
        rd(A_OTH, v);  chk("R8 unmapped reads zero", v, 32'h0);

        // R7 upper write bits ignored on source clear
        step(1'b1, 1'b1, A_SRC, 32'hFFFF_FF80, 7'h0);
        rd(A_SRC, v);  chk("R7 upper clear bits ignored", v, 32'h0000_0002);

        // R9 read returns pre-edge value and holds
        step(1'b1, 1'b0, A_SRC, 32'h0, 7'h41);
        chk("R9 read shows value before edge", bus_rdata, 32'h0000_0002);
        step(1'b1, 1'b1, A_SRC, 32'h0000_0002, 7'h0);
        chk("R9 rdata holds without read", bus_rdata, 32'h0000_0002);
        rd(A_SRC, v);  chk("R9 later read sees new value", v, 32'h0000_0041);

        // R1 reset in mid-run
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 irq cleared by reset", {31'h0, irq}, 32'h0);
        chk("R1 rdata cleared by reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_SRC, v);  chk("R1 source cleared by reset", v, 32'h0);
        rd(A_MASK, v); chk("R1 enable cleared by reset", v, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule